// File: doc/BRIEF.md
# Register-Stack Postfix Expression Evaluator

This block computes the value of an arithmetic expression written in postfix order. Tokens arrive one per handshake on a valid/ready input stream. Each token is an operand carrying a signed 16-bit value, an operator (add, subtract or multiply), or an end marker that closes the expression. Operands go onto a stack made of a small register array. A stack pointer indexes the top item, and registered flags show when the stack is full and when it is empty.

An operator takes the top two items, combines them in a single-cycle ALU, and leaves the one result in their place, all in the cycle it is accepted. When the end marker arrives, the single remaining item is returned together with a one-cycle done strobe, and the stack is then cleared for the next expression. Stack underflow, stack overflow, reserved encodings and a wrong depth at the end marker all set a sticky error flag. The top of the stack and both flags are visible on plain status pins.

Back-pressure rule: a token transfers only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for exactly the one cycle in which `res_valid` is high. A source that sees `in_ready` low must keep the same token on the bus until it is taken.

Top module: `rpn_eval`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `err`=0, `res_valid`=0, `in_ready`=1 and `top_data`=0.
- R2: An accepted operand token (`in_kind`=2'b00) puts `in_value` on top of the stack unchanged. From the next cycle `top_data` shows that value and `empty` is 0.
- R3: `full` is 1 exactly when 8 items are held and `empty` is 1 exactly when none are held. The two are never 1 together.
- R4: An accepted operator token (`in_kind`=2'b01) with at least two items removes the top two and pushes one result, so the depth drops by one. `in_op`=2'b00 adds and `in_op`=2'b01 subtracts. The item that was second from the top is the left operand, so "a b -" gives a-b. All results wrap modulo 2^16.
- R5: `in_op`=2'b10 multiplies and keeps the low 16 bits of the two's-complement product.
- R6: An operand offered while `full` is 1 is discarded: the stack and `top_data` are unchanged and `err` becomes 1.
- R7: An operator offered with fewer than two items, an operator with the reserved code `in_op`=2'b11, or a token with the reserved kind `in_kind`=2'b11 is discarded with the stack unchanged, and `err` becomes 1.
- R8: An accepted end token (`in_kind`=2'b10) with exactly one item makes `res_valid` 1 in the next cycle, for one cycle only, with `res_data` equal to that item. The stack is empty from that same cycle on.
- R9: An end token accepted with any depth other than one still gives the one-cycle `res_valid`, with `res_data`=0, sets `err`, and empties the stack.
- R10: Once set, `err` stays 1 until reset, whatever tokens follow.
- R11: `in_ready` is 0 during the `res_valid` cycle. A token held valid in that cycle is not consumed until the next cycle, and it is consumed exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Token present |
| in_ready | output | 1 | Token can be taken this cycle |
| in_kind | input | 2 | 00 operand, 01 operator, 10 end, 11 reserved |
| in_op | input | 2 | Operator code: 00 add, 01 subtract, 10 multiply, 11 reserved |
| in_value | input | 16 | Operand value, two's complement |
| res_valid | output | 1 | One-cycle done strobe |
| res_data | output | 16 | Expression result, valid while res_valid is 1 |
| err | output | 1 | Sticky error flag |
| top_data | output | 16 | Current top of stack, 0 when empty |
| full | output | 1 | Stack holds 8 items |
| empty | output | 1 | Stack holds no items |

## Verification
Two events can share a cycle. The first is an operator on a full stack: two items are popped and one is pushed in the same edge. The bench fills all eight entries and then sends an add. It expects the sum of the two top items on top, `full` low and no error, and a following push must raise `full` again without an error. The second is a result report colliding with the next token: the bench holds an operand valid through the `res_valid` cycle. It checks that the stack stays empty while `in_ready` is low, that the operand lands one cycle later, and that closing the expression returns that operand with no error, which proves it was taken only once.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [1:0] {
    TK_NUM = 2'b00,
    TK_OPR = 2'b01,
    TK_END = 2'b10,
    TK_RSV = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_RSV = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SC_NOP   = 2'b00,
    SC_PUSH  = 2'b01,
    SC_FOLD  = 2'b10,
    SC_CLEAR = 2'b11
  } stk_cmd_e;

endpackage

// File: rtl/rpn_stack.sv
module rpn_stack
  import rpn_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top,
  output logic [W-1:0]  below,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] depth
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q, sp_d, widx;
  logic          we;

  always_comb begin
    sp_d = sp_q;
    widx = sp_q;
    we   = 1'b0;
    case (cmd)
      SC_PUSH: begin
        widx = empty ? '0 : sp_q + 1'b1;
        we   = 1'b1;
        sp_d = widx;
      end
      SC_FOLD: begin
        widx = sp_q - 1'b1;
        we   = 1'b1;
        sp_d = widx;
      end
      SC_CLEAR: sp_d = '0;
      default: ;
    endcase
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else if (we && (widx == PW'(i))) mem[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      sp_q <= sp_d;
      case (cmd)
        SC_PUSH: begin
          empty <= 1'b0;
          full  <= (widx == PW'(DEPTH - 1));
        end
        SC_FOLD:  full <= 1'b0;
        SC_CLEAR: begin
          empty <= 1'b1;
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign top   = empty ? '0 : mem[sp_q];
  assign below = mem[sp_q - 1'b1];
  assign depth = empty ? '0 : CW'(sp_q) + 1'b1;

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SC_PUSH) |=> (top == $past(wdata)));
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SC_PUSH) |-> !full);
  p_fold_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SC_FOLD) |=> (depth == $past(depth) - 1'b1));
  p_fold_needs_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SC_FOLD) |-> (depth >= CW'(2)));

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = lhs + rhs;
      OP_SUB:  y = lhs - rhs;
      OP_MUL:  y = lhs * rhs;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rpn_decode.sv
module rpn_decode
  import rpn_pkg::*;
#(
  parameter int CW = 4
) (
  input  tok_kind_e     kind,
  input  alu_op_e       op,
  input  logic          full,
  input  logic [CW-1:0] depth,
  output stk_cmd_e      cmd,
  output logic          fault,
  output logic          finish,
  output logic          finish_ok
);

  always_comb begin
    cmd       = SC_NOP;
    fault     = 1'b0;
    finish    = 1'b0;
    finish_ok = 1'b0;
    case (kind)
      TK_NUM: begin
        if (full) fault = 1'b1;
        else      cmd   = SC_PUSH;
      end
      TK_OPR: begin
        if ((op == OP_RSV) || (depth < CW'(2))) fault = 1'b1;
        else                                    cmd   = SC_FOLD;
      end
      TK_END: begin
        finish    = 1'b1;
        cmd       = SC_CLEAR;
        finish_ok = (depth == CW'(1));
        fault     = (depth != CW'(1));
      end
      default: fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
  import rpn_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_kind,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_value,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         err,
  output logic [W-1:0] top_data,
  output logic         full,
  output logic         empty
);

  tok_kind_e     kind;
  alu_op_e       op;
  stk_cmd_e      dec_cmd, stk_cmd;
  logic          accept, fault, finish, finish_ok;
  logic [W-1:0]  below, alu_y, wdata;
  logic [CW-1:0] depth;

  assign kind     = tok_kind_e'(in_kind);
  assign op       = alu_op_e'(in_op);
  assign in_ready = !res_valid;
  assign accept   = in_valid && in_ready;
  assign stk_cmd  = accept ? dec_cmd : SC_NOP;
  assign wdata    = (kind == TK_NUM) ? in_value : alu_y;

  rpn_decode #(.CW(CW)) u_dec (
    .kind(kind), .op(op), .full(full), .depth(depth),
    .cmd(dec_cmd), .fault(fault), .finish(finish), .finish_ok(finish_ok)
  );

  rpn_alu #(.W(W)) u_alu (
    .op(op), .lhs(below), .rhs(top_data), .y(alu_y)
  );

  rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .cmd(stk_cmd), .wdata(wdata),
    .top(top_data), .below(below), .full(full), .empty(empty), .depth(depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      err       <= 1'b0;
    end else begin
      res_valid <= accept && finish;
      if (accept && finish) res_data <= finish_ok ? top_data : '0;
      if (accept && fault)  err <= 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_end_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind == TK_END)) |=> (empty && res_valid));
  p_bad_end_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind == TK_END) && (depth != CW'(1))) |=> (err && (res_data == '0)));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_blocked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(top_data));

endmodule

// File: tb/rpn_eval_tb.sv
`timescale 1ns/1ps
module rpn_eval_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'b00;
  logic [1:0]  in_op = 2'b00;
  logic [15:0] in_value = '0;
  logic        res_valid;
  logic [15:0] res_data;
  logic        err;
  logic [15:0] top_data;
  logic        full;
  logic        empty;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  rpn_eval u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_op(in_op), .in_value(in_value),
    .res_valid(res_valid), .res_data(res_data), .err(err),
    .top_data(top_data), .full(full), .empty(empty)
  );

  localparam logic [1:0] KN = 2'd0, KO = 2'd1, KE = 2'd2, KR = 2'd3;
  localparam logic [1:0] AD = 2'd0, SB = 2'd1, ML = 2'd2, RS = 2'd3;

  // {kind, op, value, expected top / result}
  localparam int NV = 36;
  localparam logic [35:0] VEC [NV] = '{
    {KN, AD, 16'd3, 16'd3}, {KN, AD, 16'd4, 16'd4}, {KO, ML, 16'd0, 16'd12},
    {KN, AD, 16'd5, 16'd5}, {KN, AD, 16'd6, 16'd6}, {KO, ML, 16'd0, 16'd30},
    {KO, AD, 16'd0, 16'd42}, {KE, AD, 16'd0, 16'd42},
    {KN, AD, 16'd4, 16'd4}, {KN, AD, 16'd5, 16'd5}, {KO, ML, 16'd0, 16'd20},
    {KN, AD, 16'd6, 16'd6}, {KO, ML, 16'd0, 16'd120}, {KN, AD, 16'd2, 16'd2},
    {KN, AD, 16'd3, 16'd3}, {KO, ML, 16'd0, 16'd6}, {KO, AD, 16'd0, 16'd126},
    {KN, AD, 16'd1, 16'd1}, {KO, AD, 16'd0, 16'd127}, {KE, AD, 16'd0, 16'd127},
    {KN, AD, 16'd2, 16'd2}, {KN, AD, 16'd9, 16'd9}, {KO, SB, 16'd0, 16'hFFF9},
    {KE, AD, 16'd0, 16'hFFF9},
    {KN, AD, 16'h7FFF, 16'h7FFF}, {KN, AD, 16'd1, 16'd1}, {KO, AD, 16'd0, 16'h8000},
    {KN, AD, 16'd300, 16'd300}, {KN, AD, 16'd300, 16'd300}, {KO, ML, 16'd0, 16'h5F90},
    {KO, AD, 16'd0, 16'hDF90}, {KE, AD, 16'd0, 16'hDF90},
    {KN, AD, 16'h8000, 16'h8000}, {KN, AD, 16'd1, 16'd1}, {KO, SB, 16'd0, 16'h7FFF},
    {KE, AD, 16'd0, 16'h7FFF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns at the falling edge after the token was taken
  task automatic send(input logic [1:0] k, input logic [1:0] o, input logic [15:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_op = o; in_value = v;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", 16'(empty), 16'd1);
    chk("R1 full", 16'(full), 16'd0);
    chk("R1 err", 16'(err), 16'd0);
    chk("R1 res_valid", 16'(res_valid), 16'd0);
    chk("R1 in_ready", 16'(in_ready), 16'd1);
    chk("R1 top_data", top_data, 16'd0);

    // table-driven expressions: R2 push, R4 add/sub order/wrap, R5 multiply, R8 result
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [15:0] e;
      k = VEC[i][35:34];
      e = VEC[i][15:0];
      send(k, VEC[i][33:32], VEC[i][31:16]);
      if (k == KE) begin
        chk("R8 res_valid", 16'(res_valid), 16'd1);
        chk("R8 res_data", res_data, e);
        chk("R8 empty after end", 16'(empty), 16'd1);
      end else if (k == KN) begin
        chk("R2 top after push", top_data, e);
      end else if (VEC[i][33:32] == ML) begin
        chk("R5 product", top_data, e);
      end else begin
        chk("R4 add/sub result", top_data, e);
      end
      chk("R10 no spurious err", 16'(err), 16'd0);
    end

    // R3 full flag, operator on full stack, R6 overflow, R10 sticky, R9 bad end
    do_reset();
    for (int i = 1; i <= 8; i++) send(KN, AD, 16'(i));
    chk("R3 full at eight", 16'(full), 16'd1);
    chk("R3 not empty", 16'(empty), 16'd0);
    send(KO, AD, 16'd0);
    chk("R4 fold on full", top_data, 16'd15);
    chk("R3 full clears", 16'(full), 16'd0);
    chk("R4 no err", 16'(err), 16'd0);
    send(KN, AD, 16'd100);
    chk("R3 full again", 16'(full), 16'd1);
    send(KN, AD, 16'd200);
    chk("R6 err on overflow", 16'(err), 16'd1);
    chk("R6 top unchanged", top_data, 16'd100);
    chk("R6 still full", 16'(full), 16'd1);
    send(KN, AD, 16'd5);
    chk("R10 err sticky", 16'(err), 16'd1);
    send(KE, AD, 16'd0);
    chk("R9 res_valid", 16'(res_valid), 16'd1);
    chk("R9 res_data zero", res_data, 16'd0);
    chk("R9 emptied", 16'(empty), 16'd1);
    chk("R10 err kept", 16'(err), 16'd1);

    // R7 underflow
    do_reset();
    send(KN, AD, 16'd5);
    send(KO, AD, 16'd0);
    chk("R7 underflow err", 16'(err), 16'd1);
    chk("R7 top kept", top_data, 16'd5);
    // R7 reserved operator
    do_reset();
    send(KN, AD, 16'd1);
    send(KN, AD, 16'd2);
    send(KO, RS, 16'd0);
    chk("R7 reserved op err", 16'(err), 16'd1);
    chk("R7 reserved op top", top_data, 16'd2);
    // R7 reserved kind
    do_reset();
    send(KR, AD, 16'd7);
    chk("R7 reserved kind err", 16'(err), 16'd1);
    chk("R7 reserved kind empty", 16'(empty), 16'd1);
    // R9 end on empty
    do_reset();
    send(KE, AD, 16'd0);
    chk("R9 empty end strobe", 16'(res_valid), 16'd1);
    chk("R9 empty end data", res_data, 16'd0);
    chk("R9 empty end err", 16'(err), 16'd1);

    // R11 back-pressure during result cycle
    do_reset();
    send(KN, AD, 16'd7);
    send(KE, AD, 16'd0);
    chk("R8 single value", res_data, 16'd7);
    in_valid = 1'b1; in_kind = KN; in_op = AD; in_value = 16'd99;
    chk("R11 ready low", 16'(in_ready), 16'd0);
    @(negedge clk);
    chk("R8 strobe one cycle", 16'(res_valid), 16'd0);
    chk("R11 not taken yet", 16'(empty), 16'd1);
    chk("R11 ready back", 16'(in_ready), 16'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 taken", top_data, 16'd99);
    repeat (2) @(negedge clk);
    send(KE, AD, 16'd0);
    chk("R11 taken once", res_data, 16'd99);
    chk("R11 no err", 16'(err), 16'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule